// File: doc/BRIEF.md
# Outstanding Write Response Tracker

This block keeps the tally of writes that one DMA channel has sent out but whose write responses have not yet come back. The write issuer pulses `wrIssue` for every write it launches and `wrResp` for every response it receives. The tracker returns a stall request, a 4-bit count that software can read, and the end-of-transfer bookkeeping that depends on that count.

Two mode bits select how the count is used. In drain mode (`waitAllMode`) the issuer is throttled once more than 13 writes are in flight. At the end of a transfer the end and interrupt flags are held back until the last response has returned. In lock-step mode (`waitEachMode`) the issuer is stalled whenever any write is still unanswered, so each write waits for its own response.

While completion is held back, the tracker still loads the next descriptor address at once, and it clears the channel's active bit at once when that address is zero. It does not start the fetch of the next descriptor until the drain is over.

Top module: `dma_wr_tracker`

## Requirements
- R1: Each cycle with `wrIssue` high and `wrResp` low raises `outCount` by one, saturating at 15. Each cycle with `wrResp` high and `wrIssue` low lowers it by one. The change is visible after the clock edge that samples the pulse.
- R2: A cycle with both `wrIssue` and `wrResp` high leaves `outCount` unchanged.
- R3: A `wrResp` pulse while `outCount` is 0 (without `wrIssue`) is ignored, and the count stays 0.
- R4: `xferStart` or `chanReset` forces `outCount` to 0 at the next edge, overriding any pulse in the same cycle. `chanReset` also clears `descAddr` to 0.
- R5: With `waitAllMode` high, `issueStall` is high exactly when `outCount` is 14 or 15. At 13 it is low. With both modes low it is always low.
- R6: With `waitEachMode` high, `issueStall` is high whenever `outCount` is nonzero.
- R7: When `xferDone` is sampled with `waitAllMode` low, or with `outCount` 0, the block does all of the following one edge later for one cycle: `descAddr` takes `nextDescAddr`; `endFlagSet` pulses; `intFlagSet` pulses if `intEnable` was high; `descFetch` pulses if the address is nonzero, otherwise `activeClear` pulses.
- R8: When `xferDone` is sampled with `waitAllMode` high and `outCount` nonzero, the block does all of the following one edge later: `descAddr` takes `nextDescAddr`; `activeClear` pulses if that address is zero; `waitingOut` rises. Neither `endFlagSet`, `intFlagSet` nor `descFetch` pulses.
- R9: While `waitingOut` is high, the first cycle in which `outCount` reads 0 is followed, one edge later, by all of these: `waitingOut` falls; `endFlagSet` pulses; `intFlagSet` pulses if `intEnable` was high at `xferDone`; `descFetch` pulses if the loaded address is nonzero.
- R10: `chanReset` during a drain drops `waitingOut` at the next edge, and no end, interrupt or fetch pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| chanReset | input | 1 | Channel reset pulse |
| xferStart | input | 1 | Start of a new transfer, clears the count |
| waitAllMode | input | 1 | Drain mode: throttle above 13, defer completion |
| waitEachMode | input | 1 | Lock-step mode: one write in flight at a time |
| intEnable | input | 1 | Interrupt requested for the current descriptor |
| wrIssue | input | 1 | A write was issued this cycle |
| wrResp | input | 1 | A write response arrived this cycle |
| xferDone | input | 1 | Last data of the current descriptor has been issued |
| nextDescAddr | input | ADDR_W | Address of the next descriptor |
| issueStall | output | 1 | Hold off further writes |
| outCount | output | CNT_W | Writes awaiting a response |
| waitingOut | output | 1 | Waiting for outstanding writes |
| endFlagSet | output | 1 | One-cycle pulse that sets the end flag |
| intFlagSet | output | 1 | One-cycle pulse that sets the interrupt flag |
| descFetch | output | 1 | One-cycle pulse that starts the fetch of the next descriptor |
| activeClear | output | 1 | One-cycle pulse that clears the active bit |
| descAddr | output | ADDR_W | Current descriptor address register |

## Verification
The hardest state to reach is a drain in progress. Getting there needs drain mode, a nonzero count and an `xferDone` pulse all in the same cycle. The deferred pulses then have to be seen exactly one edge after the count falls to zero. The bench first builds up a count with issue pulses, then signals the end of transfer, then returns responses one by one. It checks at each step that no end or fetch pulse appears early. It then repeats the drain with a zero next address, and once more interrupted by a channel reset.

// File: rtl/dma_wr_tracker_pkg.sv
package dma_wr_tracker_pkg;

  typedef struct packed {
    logic cntClear;
    logic addrLoad;
  } trkStrobe_t;

  typedef enum logic [0:0] {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } trkState_e;

endpackage

// File: rtl/dma_wr_tracker_dp.sv
module dma_wr_tracker_dp
  import dma_wr_tracker_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int STALL_LIMIT = 13,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  trkStrobe_t        strobe,
  input  logic              wrIssue,
  input  logic              wrResp,
  input  logic              waitAllMode,
  input  logic              waitEachMode,
  input  logic              chanReset,
  input  logic [ADDR_W-1:0] nextDescAddr,
  output logic [CNT_W-1:0]  count,
  output logic              cntZero,
  output logic              issueStall,
  output logic [ADDR_W-1:0] descAddr
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(STALL_LIMIT);

  logic incEn;
  logic decEn;

  assign incEn = wrIssue && !wrResp && (count != CNT_MAX);
  assign decEn = wrResp && !wrIssue && (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClear) begin
      count <= '0;
    end else if (incEn) begin
      count <= count + 1'b1;
    end else if (decEn) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || chanReset) begin
      descAddr <= '0;
    end else if (strobe.addrLoad) begin
      descAddr <= nextDescAddr;
    end
  end

  assign cntZero    = (count == '0);
  assign issueStall = (waitAllMode && (count > LIMIT)) ||
                      (waitEachMode && !cntZero);

  // R3: a lone response at zero must not wrap the count
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && wrResp && !wrIssue && !strobe.cntClear) |=> (count == '0));

  // R2: simultaneous issue and response hold the count
  assert_hold_on_both_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrIssue && wrResp && !strobe.cntClear) |=> $stable(count));

  // R4: a clear always lands
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> cntZero);

  // R1: count never moves by more than one per cycle
  assert_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntClear |=> ((count == $past(count)) ||
                          (count == $past(count) + 1'b1) ||
                          (count == $past(count) - 1'b1)));

endmodule

// File: rtl/dma_wr_tracker_ctrl.sv
module dma_wr_tracker_ctrl
  import dma_wr_tracker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanReset,
  input  logic       xferStart,
  input  logic       xferDone,
  input  logic       waitAllMode,
  input  logic       intEnable,
  input  logic       nextIsZero,
  input  logic       cntZero,
  output trkStrobe_t strobe,
  output logic       waitingOut,
  output logic       endFlagSet,
  output logic       intFlagSet,
  output logic       descFetch,
  output logic       activeClear
);

  trkState_e state;
  logic      pendInt;
  logic      pendFetch;
  logic      doneNow;

  assign doneNow = (state == ST_RUN) && xferDone && !chanReset;

  assign strobe.cntClear = chanReset || xferStart;
  assign strobe.addrLoad = doneNow;

  always_ff @(posedge clk) begin
    if (!rstN || chanReset) begin
      state       <= ST_RUN;
      pendInt     <= 1'b0;
      pendFetch   <= 1'b0;
      endFlagSet  <= 1'b0;
      intFlagSet  <= 1'b0;
      descFetch   <= 1'b0;
      activeClear <= 1'b0;
    end else begin
      endFlagSet  <= 1'b0;
      intFlagSet  <= 1'b0;
      descFetch   <= 1'b0;
      activeClear <= 1'b0;
      case (state)
        ST_RUN: begin
          if (doneNow) begin
            activeClear <= nextIsZero;
            if (!waitAllMode || cntZero) begin
              endFlagSet <= 1'b1;
              intFlagSet <= intEnable;
              descFetch  <= !nextIsZero;
            end else begin
              state     <= ST_DRAIN;
              pendInt   <= intEnable;
              pendFetch <= !nextIsZero;
            end
          end
        end
        ST_DRAIN: begin
          if (cntZero) begin
            state      <= ST_RUN;
            endFlagSet <= 1'b1;
            intFlagSet <= pendInt;
            descFetch  <= pendFetch;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign waitingOut = (state == ST_DRAIN);

  // R7: fetching and stopping are mutually exclusive
  assert_fetch_or_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(descFetch && activeClear));

  // R8: completion flags stay down while draining
  assert_no_end_in_drain_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitingOut |-> !(endFlagSet || intFlagSet || descFetch));

  // R9: leaving the drain without a reset raises the end flag
  assert_drain_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (waitingOut && cntZero && !chanReset) |=> (endFlagSet && !waitingOut));

  // R10: reset drops the wait and suppresses the flags
  assert_reset_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    chanReset |=> (!waitingOut && !endFlagSet && !descFetch));

endmodule

// File: rtl/dma_wr_tracker.sv
module dma_wr_tracker
  import dma_wr_tracker_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int STALL_LIMIT = 13,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanReset,
  input  logic              xferStart,
  input  logic              waitAllMode,
  input  logic              waitEachMode,
  input  logic              intEnable,
  input  logic              wrIssue,
  input  logic              wrResp,
  input  logic              xferDone,
  input  logic [ADDR_W-1:0] nextDescAddr,
  output logic              issueStall,
  output logic [CNT_W-1:0]  outCount,
  output logic              waitingOut,
  output logic              endFlagSet,
  output logic              intFlagSet,
  output logic              descFetch,
  output logic              activeClear,
  output logic [ADDR_W-1:0] descAddr
);

  trkStrobe_t strobe;
  logic       cntZero;
  logic       nextIsZero;

  assign nextIsZero = (nextDescAddr == '0);

  dma_wr_tracker_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .chanReset   (chanReset),
    .xferStart   (xferStart),
    .xferDone    (xferDone),
    .waitAllMode (waitAllMode),
    .intEnable   (intEnable),
    .nextIsZero  (nextIsZero),
    .cntZero     (cntZero),
    .strobe      (strobe),
    .waitingOut  (waitingOut),
    .endFlagSet  (endFlagSet),
    .intFlagSet  (intFlagSet),
    .descFetch   (descFetch),
    .activeClear (activeClear)
  );

  dma_wr_tracker_dp #(
    .CNT_W       (CNT_W),
    .STALL_LIMIT (STALL_LIMIT),
    .ADDR_W      (ADDR_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrIssue      (wrIssue),
    .wrResp       (wrResp),
    .waitAllMode  (waitAllMode),
    .waitEachMode (waitEachMode),
    .chanReset    (chanReset),
    .nextDescAddr (nextDescAddr),
    .count        (outCount),
    .cntZero      (cntZero),
    .issueStall   (issueStall),
    .descAddr     (descAddr)
  );

  // R5: in drain mode alone, a stall implies the count is above the limit
  assert_stall_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issueStall && !waitEachMode) |-> (int'(outCount) > STALL_LIMIT));

endmodule

// File: tb/dma_wr_tracker_tb_top.sv
`timescale 1ns/1ps
module dma_wr_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanReset = 1'b0;
  logic        xferStart = 1'b0;
  logic        waitAllMode = 1'b0;
  logic        waitEachMode = 1'b0;
  logic        intEnable = 1'b0;
  logic        wrIssue = 1'b0;
  logic        wrResp = 1'b0;
  logic        xferDone = 1'b0;
  logic [31:0] nextDescAddr = '0;
  logic        issueStall;
  logic [3:0]  outCount;
  logic        waitingOut;
  logic        endFlagSet;
  logic        intFlagSet;
  logic        descFetch;
  logic        activeClear;
  logic [31:0] descAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_wr_tracker dut_i (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .xferStart(xferStart),
    .waitAllMode(waitAllMode), .waitEachMode(waitEachMode),
    .intEnable(intEnable), .wrIssue(wrIssue), .wrResp(wrResp),
    .xferDone(xferDone), .nextDescAddr(nextDescAddr),
    .issueStall(issueStall), .outCount(outCount), .waitingOut(waitingOut),
    .endFlagSet(endFlagSet), .intFlagSet(intFlagSet), .descFetch(descFetch),
    .activeClear(activeClear), .descAddr(descAddr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issueN(input int n);
    for (int i = 0; i < n; i++) begin
      wrIssue = 1'b1;
      tick();
    end
    wrIssue = 1'b0;
  endtask

  task automatic respN(input int n);
    for (int i = 0; i < n; i++) begin
      wrResp = 1'b1;
      tick();
    end
    wrResp = 1'b0;
  endtask

  task automatic clearCount();
    xferStart = 1'b1;
    tick();
    xferStart = 1'b0;
  endtask

  task automatic pulseDone(input logic [31:0] addr, input logic ie);
    nextDescAddr = addr;
    intEnable = ie;
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
  endtask

  task automatic testReset();
    chk("R4", "count after reset", outCount, 0);
    chk("R5", "stall after reset", issueStall, 0);
    chk("R8", "waiting after reset", waitingOut, 0);
    chk("R4", "descAddr after reset", descAddr, 0);
  endtask

  task automatic testCounting();
    issueN(3);
    chk("R1", "count after 3 issues", outCount, 3);
    respN(1);
    chk("R1", "count after 1 response", outCount, 2);
    wrIssue = 1'b1; wrResp = 1'b1;
    tick();
    wrIssue = 1'b0; wrResp = 1'b0;
    chk("R2", "count with both pulses", outCount, 2);
    wrIssue = 1'b1; xferStart = 1'b1;
    tick();
    wrIssue = 1'b0; xferStart = 1'b0;
    chk("R4", "xferStart overrides issue", outCount, 0);
    respN(2);
    chk("R3", "response at zero ignored", outCount, 0);
    issueN(17);
    chk("R1", "count saturates", outCount, 15);
    chanReset = 1'b1;
    tick();
    chanReset = 1'b0;
    chk("R4", "chanReset clears count", outCount, 0);
  endtask

  task automatic testThrottle();
    waitAllMode = 1'b1;
    issueN(13);
    chk("R5", "count at limit", outCount, 13);
    chk("R5", "no stall at 13", issueStall, 0);
    issueN(1);
    chk("R5", "stall at 14", issueStall, 1);
    waitAllMode = 1'b0;
    #1;
    chk("R5", "no stall with modes off", issueStall, 0);
    clearCount();
    waitEachMode = 1'b1;
    #1;
    chk("R6", "no stall at zero", issueStall, 0);
    issueN(1);
    chk("R6", "stall with one in flight", issueStall, 1);
    respN(1);
    chk("R6", "stall released", issueStall, 0);
    waitEachMode = 1'b0;
  endtask

  task automatic testImmediateDone();
    waitAllMode = 1'b1;
    clearCount();
    pulseDone(32'h0000_0100, 1'b1);
    chk("R7", "end pulse", endFlagSet, 1);
    chk("R7", "int pulse", intFlagSet, 1);
    chk("R7", "fetch pulse", descFetch, 1);
    chk("R7", "no active clear", activeClear, 0);
    chk("R7", "descAddr loaded", descAddr, 32'h100);
    chk("R7", "not waiting", waitingOut, 0);
    tick();
    chk("R7", "end pulse is one cycle", endFlagSet, 0);
    waitAllMode = 1'b0;
    issueN(2);
    pulseDone(32'h0, 1'b0);
    chk("R7", "end without drain mode", endFlagSet, 1);
    chk("R7", "int held low", intFlagSet, 0);
    chk("R7", "stop on zero next", activeClear, 1);
    chk("R7", "no fetch on zero next", descFetch, 0);
    tick();
  endtask

  task automatic testDrain();
    waitAllMode = 1'b1;
    clearCount();
    issueN(2);
    pulseDone(32'h0000_0240, 1'b1);
    chk("R8", "waiting raised", waitingOut, 1);
    chk("R8", "end held back", endFlagSet, 0);
    chk("R8", "int held back", intFlagSet, 0);
    chk("R8", "fetch held back", descFetch, 0);
    chk("R8", "address loaded early", descAddr, 32'h240);
    chk("R8", "active kept", activeClear, 0);
    respN(2);
    chk("R9", "still waiting at count edge", waitingOut, 1);
    chk("R9", "no end yet", endFlagSet, 0);
    tick();
    chk("R9", "waiting dropped", waitingOut, 0);
    chk("R9", "deferred end", endFlagSet, 1);
    chk("R9", "deferred int", intFlagSet, 1);
    chk("R9", "deferred fetch", descFetch, 1);
    tick();
    issueN(1);
    pulseDone(32'h0, 1'b0);
    chk("R8", "active cleared while draining", activeClear, 1);
    chk("R8", "waiting with zero next", waitingOut, 1);
    respN(1);
    tick();
    chk("R9", "end after zero-next drain", endFlagSet, 1);
    chk("R9", "no fetch for zero next", descFetch, 0);
    tick();
  endtask

  task automatic testResetAbort();
    waitAllMode = 1'b1;
    clearCount();
    issueN(3);
    pulseDone(32'h0000_0380, 1'b1);
    chk("R10", "drain entered", waitingOut, 1);
    chanReset = 1'b1;
    tick();
    chanReset = 1'b0;
    chk("R10", "waiting dropped by reset", waitingOut, 0);
    chk("R10", "no end after reset", endFlagSet, 0);
    chk("R4", "descAddr cleared", descAddr, 0);
    tick();
    chk("R10", "still no end", endFlagSet, 0);
    chk("R10", "no fetch", descFetch, 0);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testCounting();
    testThrottle();
    testImmediateDone();
    testDrain();
    testResetAbort();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule